// File: doc/BRIEF.md
# I2C Read-Only Slave with Data-Ready Interrupt

This block is an I2C slave that only answers read transactions. On the chip side, bytes enter an outbound FIFO through a valid/ready push port. On the bus side, an active-low interrupt output tells the bus master that bytes are waiting. The master responds by issuing a start condition, addressing the slave with the read bit set, and clocking bytes out. The block watches SCL and SDA through two-flop synchronisers in a system clock that runs at least eight times faster than SCL. It detects start and stop conditions and shifts each byte out MSB first. It drives SDA low only through an open-drain enable.

The interrupt carries the end-of-data signal for the bus. It stays low while more bytes remain after the one being sent. On the SCL falling edge that ends the last data bit of the final queued byte, it goes high and then stays high through the ACK clock. The master reads the pin in the ACK slot: if it is low, the master ACKs and continues; if it is high, the master NACKs and sends a stop. The whole queue is meant to be drained in one transaction. If a stop follows a NACK while bytes remain, those bytes are discarded.

Top module: `i2c_irq_tx_slave`

## Requirements
- R1: After reset, irq_n is 1, sda_oe is 0 and push_ready is 1.
- R2: A byte is accepted when push_valid and push_ready are both 1 at a clock edge. push_ready is 0 while DEPTH bytes are held, and a push attempted then is lost.
- R3: With the bus idle and irq_n high, a byte pushed into an empty queue makes irq_n go low on the second clock edge after the push. irq_n is still high after the first edge.
- R4: The first byte after a start carries the 7-bit address MSB first, then the R/W bit, where 1 means read. When the address equals DEV_ADDR and R/W is 1, the slave pulls SDA low (sda_oe=1) during the ninth clock.
- R5: If the address differs, or R/W is 0, the slave gives no ACK and keeps SDA released until the next start. A repeated start, sent without a stop, restarts address decoding.
- R6: Data bytes leave in push order, MSB first. sda_oe changes only while SCL is low, except when a start or stop forces the release.
- R7: While more bytes remain queued after the byte being sent, irq_n stays low through that byte and its ACK clock. This includes a byte pushed during the transfer, before the last data bit falls.
- R8: At the SCL falling edge ending bit 0 of a byte, irq_n goes high if the queue is empty. It stays high at least through the following ACK clock.
- R9: The slave releases SDA (sda_oe=0) during every master ACK/NACK bit. An ACK makes it send the next byte; a NACK makes it stop driving until the next start.
- R10: A stop that follows a NACK flushes any bytes still queued, and irq_n then returns high. A later push and read delivers only the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Byte offered to the outbound queue |
| push_data | input | 8 | Byte to queue |
| push_ready | output | 1 | Queue has room |
| scl_in | input | 1 | Bus clock as seen on the pin |
| sda_in | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_n | output | 1 | Active-low data-ready interrupt |

## Verification
Two events can fall in the same window: the release decision at the last data bit, and a refill of the queue from the chip side. The bench forks a push into the middle of the final queued byte. The interrupt must then stay low in the ACK slot, and the pushed byte must follow after the ACK. The bench also makes a stop-triggered flush coincide with bytes still waiting. It judges that case by the interrupt level after the stop and by the contents of the next read. Every expected byte and level comes from a behavioural queue in the bench.

// File: rtl/i2c_irq_tx_slave.sv
module i2c_irq_tx_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h3A,
  parameter int         DEPTH    = 16,
  localparam int        AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int        CW       = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  output logic       push_ready,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       irq_n
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_TX, S_MACK, S_HOLD} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_fire, pop, flush;

  function automatic logic [AW-1:0] nxt_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ready = (count < CW'(DEPTH));
  assign push_fire  = push_valid & push_ready;

  always_ff @(posedge clk)
    if (push_fire) mem[wr_ptr] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_fire) wr_ptr <= nxt_ptr(wr_ptr);
      if (flush) begin
        rd_ptr <= wr_ptr;
        count  <= CW'(push_fire);
      end else begin
        if (pop) rd_ptr <= nxt_ptr(rd_ptr);
        count <= count + CW'(push_fire) - CW'(pop);
      end
    end

  st_t        state;
  logic [3:0] bitc;
  logic [7:0] sh;
  logic       oe_r, hit, acked, nack_seen, irq_n_r;
  logic       last_fall, load;
  logic [7:0] next_byte;

  assign last_fall = (state == S_TX) && scl_fall && (bitc == 4'd7);
  assign load      = scl_fall && ((state == S_AACK) || (state == S_MACK && acked));
  assign pop       = load && (count != '0);
  assign flush     = stop_c && nack_seen && (count != '0);
  assign next_byte = (count != '0) ? mem[rd_ptr] : 8'hFF;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      bitc      <= '0;
      sh        <= '0;
      oe_r      <= 1'b0;
      hit       <= 1'b0;
      acked     <= 1'b0;
      nack_seen <= 1'b0;
    end else if (start_c) begin
      state     <= S_ADDR;
      bitc      <= '0;
      oe_r      <= 1'b0;
      nack_seen <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE;
      oe_r  <= 1'b0;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bitc <= bitc + 4'd1;
            if (bitc == 4'd7) hit <= ({sh[6:0], sda_s} == {DEV_ADDR, 1'b1});
          end else if (scl_fall && bitc == 4'd8) begin
            state <= hit ? S_AACK : S_HOLD;
            oe_r  <= hit;
          end
        end
        S_AACK: if (scl_fall) begin
          sh    <= next_byte;
          oe_r  <= ~next_byte[7];
          bitc  <= '0;
          state <= S_TX;
        end
        S_TX: if (scl_fall) begin
          if (bitc == 4'd7) begin
            oe_r  <= 1'b0;
            state <= S_MACK;
          end else begin
            sh   <= {sh[6:0], 1'b0};
            oe_r <= ~sh[6];
            bitc <= bitc + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) acked <= ~sda_s;
          if (scl_fall) begin
            if (acked) begin
              sh    <= next_byte;
              oe_r  <= ~next_byte[7];
              bitc  <= '0;
              state <= S_TX;
            end else begin
              state     <= S_HOLD;
              nack_seen <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 irq_n_r <= 1'b1;
    else if (state == S_IDLE)   irq_n_r <= (count == '0);
    else if (last_fall)         irq_n_r <= (count == '0);

  assign sda_oe = oe_r;
  assign irq_n  = irq_n_r;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r3_idle_irq_follows_queue: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state == S_IDLE) && $past(count != '0)) |-> !irq_n);

  a_r6_sda_quiet_while_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_c && !stop_c) |=> $stable(sda_oe));

  a_r8_irq_steady_in_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && $past(state == S_MACK)) |-> $stable(irq_n));

  a_r9_released_for_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK) |-> !sda_oe);

  a_r5_silent_when_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> !sda_oe);

endmodule

// File: tb/sim_i2c_irq_tx_slave.sv
module sim_i2c_irq_tx_slave;
  localparam logic [6:0] ADDR = 7'h3A;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic push_ready, sda_oe, irq_n;
  logic scl_m = 1'b1, sda_m = 1'b1;
  wire  sda_line = sda_m & ~sda_oe;

  int nchk = 0, nfail = 0;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  i2c_irq_tx_slave #(.DEV_ADDR(ADDR), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .push_ready(push_ready), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .irq_n(irq_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_b(input logic [7:0] b);
    push_valid = 1'b1; push_data = b;
    @(negedge clk);
    push_valid = 1'b0;
    q.push_back(b);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(8); scl_m = 1'b1; wt(8); sda_m = 1'b0; wt(8); scl_m = 1'b0; wt(4);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(8); scl_m = 1'b1; wt(8); sda_m = 1'b1; wt(8);
  endtask

  task automatic clk_bit(input bit mb, output bit rb);
    sda_m = mb; wt(8); scl_m = 1'b1; wt(8); rb = sda_line; scl_m = 1'b0;
  endtask

  task automatic send_addr(input logic [6:0] a, input bit rw, output bit ack);
    bit rb;
    for (int i = 6; i >= 0; i--) clk_bit(a[i], rb);
    clk_bit(rw, rb);
    clk_bit(1'b1, rb);
    ack = !rb;
  endtask

  task automatic read_byte(input bit force_nack, output logic [7:0] d,
                           output bit ilo, output bit ihi, output bit oe_ack);
    bit rb;
    d = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, rb); d = {d[6:0], rb}; end
    sda_m = 1'b1; wt(8); ilo = irq_n;
    sda_m = (force_nack || ilo); wt(4);
    scl_m = 1'b1; wt(8); ihi = irq_n; oe_ack = sda_oe; scl_m = 1'b0;
  endtask

  task automatic drain(input string tag);
    logic [7:0] d, e;
    bit ilo, ihi, oe;
    do begin
      e = q.pop_front();
      read_byte(1'b0, d, ilo, ihi, oe);
      check(d == e, "R6 byte order", d, e);
      check(oe == 1'b0, "R9 ack released", oe, 0);
      if (q.size() != 0) check(ilo == 1'b0, {"R7 irq low ", tag}, ilo, 0);
      else begin
        check(ilo == 1'b1, {"R8 irq high at last bit ", tag}, ilo, 1);
        check(ihi == 1'b1, {"R8 irq held through ack ", tag}, ihi, 1);
      end
    end while (!ilo);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit ack, ilo, ihi, oe;
    wt(3); rst_n = 1'b1; wt(2);
    check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
    check(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    check(push_ready == 1'b1, "R1 push_ready", push_ready, 1);

    push_b(8'hA5);
    check(irq_n == 1'b1, "R3 irq after one edge", irq_n, 1);
    wt(1);
    check(irq_n == 1'b0, "R3 irq after two edges", irq_n, 0);
    push_b(8'h3C); push_b(8'h81); wt(2);

    bus_start; send_addr(ADDR, 1'b1, ack);
    check(ack == 1'b1, "R4 address ack", ack, 1);
    drain("basic");
    bus_stop;
    check(irq_n == 1'b1, "R8 irq stays high after stop", irq_n, 1);

    push_b(8'h5A); wt(4);
    bus_start; send_addr(ADDR ^ 7'h01, 1'b1, ack);
    check(ack == 1'b0, "R5 wrong address no ack", ack, 0);
    read_byte(1'b1, d, ilo, ihi, oe);
    check(d == 8'hFF, "R5 bus released when unaddressed", d, 8'hFF);
    check(irq_n == 1'b0, "R5 irq unaffected", irq_n, 0);
    bus_stop;
    bus_start; send_addr(ADDR, 1'b0, ack);
    check(ack == 1'b0, "R5 write not acked", ack, 0);
    bus_stop;

    bus_start; send_addr(ADDR ^ 7'h40, 1'b1, ack);
    bus_start; send_addr(ADDR, 1'b1, ack);
    check(ack == 1'b1, "R5 repeated start decodes", ack, 1);
    drain("rstart");
    bus_stop;

    push_b(8'h11); push_b(8'h22); push_b(8'h33); push_b(8'h44); wt(4);
    bus_start; send_addr(ADDR, 1'b1, ack);
    read_byte(1'b1, d, ilo, ihi, oe);
    check(d == 8'h11, "R10 first byte", d, 8'h11);
    check(ilo == 1'b0, "R7 irq low with bytes left", ilo, 0);
    check(oe == 1'b0, "R9 released on nack", oe, 0);
    bus_stop; wt(4);
    check(irq_n == 1'b1, "R10 flush raises irq", irq_n, 1);
    q.delete();
    push_b(8'h77); wt(4);
    check(irq_n == 1'b0, "R10 irq after new push", irq_n, 0);
    bus_start; send_addr(ADDR, 1'b1, ack);
    drain("after flush");
    bus_stop;

    push_b(8'hC3); wt(4);
    bus_start; send_addr(ADDR, 1'b1, ack);
    fork
      begin wt(40); push_b(8'h96); end
      drain("refill");
    join
    bus_stop;

    for (int i = 0; i < DEPTH; i++) push_b(8'(i * 17 + 3));
    check(push_ready == 1'b0, "R2 full", push_ready, 0);
    push_valid = 1'b1; push_data = 8'hEE; @(negedge clk); push_valid = 1'b0;
    wt(4);
    bus_start; send_addr(ADDR, 1'b1, ack);
    drain("full");
    bus_stop; wt(4);
    check(irq_n == 1'b1, "R2 extra push dropped", irq_n, 1);
    check(push_ready == 1'b1, "R2 ready after drain", push_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule